// File: doc/BRIEF.md
# Mixed-Width Dual-Port RAM

This block is a synchronous memory with two fully independent access ports that share one storage array of fixed bit capacity. Each port has its own enable, write enable, address and data. Each port's data width is set by a parameter to the full row width, one half of it, or one quarter of it. A narrower port sees proportionally more addresses. The extra low-order address bits of a narrow port pick which slice of a stored row it reads or writes.

A typical use packs data on a wide port and drains it through a narrow port at a higher access rate, or the reverse. Another use splits the array between the two ports as two private regions of any size, as long as their address ranges stay apart. Both ports are clocked by one clock. The difference in access rate comes from how often each port's enable is raised.

Top module: `mwdp_ram`

## Requirements
- R1: Port depth times port width equals ROWS times WIDE_W for every port. A port's address width is log2(ROWS) plus log2(WIDE_W / port width), so the highest narrow address reaches the top slice of the last row.
- R2: A narrow address n refers to row n >> s and slice n mod 2^s, where s = log2(ratio). Slice 0 is the least-significant port-width bits of the row, and slice k starts at bit k times the port width.
- R3: With the enable high, read data for an address is on the port's data output on the first clock edge after the address is presented.
- R4: A write on a port returns, on that same port, the contents the addressed location held before the write (read-first).
- R5: A port reading a location in the same cycle that the other port writes it gets the old contents. A read of that location in any later cycle gets the new contents.
- R6: A narrow write changes only its own slice. The other slices of the row keep their values.
- R7: While a port's enable is low, that port's read data output holds its last value.
- R8: A write enable raised while the port's enable is low writes nothing.
- R9: While reset is asserted, and after it is released until the first enabled read, both read data outputs are zero. Reset is asynchronous, active low, and released inside the block after two clock edges.
- R10: The width ratio WIDE_W / port width must be 1, 2 or 4. Any other value stops elaboration, and each of the three allowed ratios builds and works.
- R11: When the two ports write address ranges that never overlap, whether in the same cycles or not, each region keeps exactly what its own port wrote.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable, qualified by a_en |
| a_addr | input | log2(ROWS)+log2(WIDE_W/A_W) | Port A word address |
| a_wdata | input | A_W | Port A write data |
| a_rdata | output | A_W | Port A registered read data |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable, qualified by b_en |
| b_addr | input | log2(ROWS)+log2(WIDE_W/B_W) | Port B word address |
| b_wdata | input | B_W | Port B write data |
| b_rdata | output | B_W | Port B registered read data |

## Verification
Some properties are checked on every cycle. An idle port must hold its read data. An enabled write must assert a lane mask exactly one port width wide, and no mask bit may rise without a write. The lanes a write targets must hold the written bits on the next edge.

Other behaviour can only be shown by the bench's scenarios against its own shadow model of the rows. This covers the mapping of narrow addresses to slices, the read-first results on the writing port and on the other port, a write enable ignored while the port is disabled, two ports working in separate regions, the top-address boundary, and the half-width configuration.

// File: rtl/mwdp_pkg.sv
package mwdp_pkg;

  localparam int MAX_RATIO = 4;

  function automatic bit ratio_ok(int wide_w, int port_w);
    int r;
    if (port_w <= 0 || (wide_w % port_w) != 0) return 1'b0;
    r = wide_w / port_w;
    return (r == 1) || (r == 2) || (r == MAX_RATIO);
  endfunction

  function automatic int sel_bits(int wide_w, int port_w);
    return $clog2(wide_w / port_w);
  endfunction

  function automatic int port_aw(int rows, int wide_w, int port_w);
    return $clog2(rows) + sel_bits(wide_w, port_w);
  endfunction

endpackage

// File: rtl/mwdp_port_map.sv
module mwdp_port_map
  import mwdp_pkg::*;
#(
  parameter int WIDE_W = 32,
  parameter int PORT_W = 8,
  parameter int ROWS   = 64
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   en,
  input  logic                                   we,
  input  logic [port_aw(ROWS,WIDE_W,PORT_W)-1:0] addr,
  input  logic [PORT_W-1:0]                      wdata,
  input  logic [WIDE_W-1:0]                      rword,
  output logic [$clog2(ROWS)-1:0]                row,
  output logic [WIDE_W-1:0]                      wmask,
  output logic [WIDE_W-1:0]                      wword,
  output logic [PORT_W-1:0]                      rdata
);

  localparam int RATIO   = WIDE_W / PORT_W;
  localparam int SEL_W   = sel_bits(WIDE_W, PORT_W);
  localparam int SEL_EW  = (SEL_W == 0) ? 1 : SEL_W;
  localparam int ROW_AW  = $clog2(ROWS);
  localparam int PORT_AW = ROW_AW + SEL_W;

  if (!ratio_ok(WIDE_W, PORT_W)) begin : g_bad_ratio
    $error("mwdp_port_map: row width over port width must be 1, 2 or 4");
  end

  logic              wr;
  logic [SEL_EW-1:0] sel_now;
  logic [SEL_EW-1:0] sel_d;
  logic [SEL_EW-1:0] sel_q;

  assign wr = en & we;

  // address split: row index in the high bits, slice index in the low bits
  if (RATIO == 1) begin : g_full
    assign row     = addr;
    assign sel_now = '0;
  end else begin : g_narrow
    assign row     = addr[PORT_AW-1:SEL_W];
    assign sel_now = addr[SEL_W-1:0];
  end

  // write lane decode: one port-width lane per slice
  for (genvar k = 0; k < RATIO; k++) begin : g_lane
    assign wmask[k*PORT_W +: PORT_W] = {PORT_W{wr && (sel_now == SEL_EW'(k))}};
  end

  assign wword = {RATIO{wdata}};

  // slice select follows the row read register
  always_comb begin
    sel_d = sel_q;
    if (en) sel_d = sel_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign rdata = rword[int'(sel_q)*PORT_W +: PORT_W];

  // R6: a write opens exactly one lane of one port width
  assert_lane_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && we) |-> ($countones(wmask) == PORT_W));

  // R8: no lane opens without an enabled write
  assert_no_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && we) |-> (wmask == '0));

endmodule

// File: rtl/mwdp_store.sv
module mwdp_store #(
  parameter int WIDE_W = 32,
  parameter int ROWS   = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    a_en,
  input  logic [$clog2(ROWS)-1:0] a_row,
  input  logic [WIDE_W-1:0]       a_mask,
  input  logic [WIDE_W-1:0]       a_word,
  output logic [WIDE_W-1:0]       a_rword,
  input  logic                    b_en,
  input  logic [$clog2(ROWS)-1:0] b_row,
  input  logic [WIDE_W-1:0]       b_mask,
  input  logic [WIDE_W-1:0]       b_word,
  output logic [WIDE_W-1:0]       b_rword
);

  if ((1 << $clog2(ROWS)) != ROWS) begin : g_bad_rows
    $error("mwdp_store: ROWS must be a power of two");
  end

  logic [WIDE_W-1:0] mem [ROWS];

  logic              a_wr, b_wr, same_row;
  logic [WIDE_W-1:0] a_cur, b_cur;
  logic [WIDE_W-1:0] a_new, b_new, merged;
  logic [WIDE_W-1:0] a_rword_d, b_rword_d;

  always_comb begin
    a_wr      = |a_mask;
    b_wr      = |b_mask;
    same_row  = (a_row == b_row);
    a_cur     = mem[a_row];
    b_cur     = mem[b_row];
    a_new     = (a_cur & ~a_mask) | (a_word & a_mask);
    b_new     = (b_cur & ~b_mask) | (b_word & b_mask);
    // both ports in one row: keep each port's lanes, port A wins shared bits
    merged    = (a_cur & ~(a_mask | b_mask)) | (a_word & a_mask) |
                (b_word & b_mask & ~a_mask);
    a_rword_d = a_en ? a_cur : a_rword;
    b_rword_d = b_en ? b_cur : b_rword;
  end

  // storage array: no reset, lane-masked row update
  always_ff @(posedge clk) begin
    if (a_wr && b_wr && same_row) begin
      mem[a_row] <= merged;
    end else begin
      if (a_wr) mem[a_row] <= a_new;
      if (b_wr) mem[b_row] <= b_new;
    end
  end

  // read registers sample the row before this edge's update (read-first)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rword <= '0;
      b_rword <= '0;
    end else begin
      a_rword <= a_rword_d;
      b_rword <= b_rword_d;
    end
  end

  // R6: port A's written lanes hold its data after the edge
  assert_write_lands_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && !(b_wr && same_row)) |=>
      ((mem[$past(a_row)] & $past(a_mask)) == ($past(a_word) & $past(a_mask))));

  // R6: port B's written lanes hold its data after the edge
  assert_write_lands_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (b_wr && !(a_wr && same_row)) |=>
      ((mem[$past(b_row)] & $past(b_mask)) == ($past(b_word) & $past(b_mask))));

endmodule

// File: rtl/mwdp_ram.sv
module mwdp_ram
  import mwdp_pkg::*;
#(
  parameter int WIDE_W = 32,
  parameter int ROWS   = 64,
  parameter int A_W    = 32,
  parameter int B_W    = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                a_en,
  input  logic                                a_we,
  input  logic [port_aw(ROWS,WIDE_W,A_W)-1:0] a_addr,
  input  logic [A_W-1:0]                      a_wdata,
  output logic [A_W-1:0]                      a_rdata,
  input  logic                                b_en,
  input  logic                                b_we,
  input  logic [port_aw(ROWS,WIDE_W,B_W)-1:0] b_addr,
  input  logic [B_W-1:0]                      b_wdata,
  output logic [B_W-1:0]                      b_rdata
);

  localparam int ROW_AW = $clog2(ROWS);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe_d, rst_pipe_q;
  logic       rst_q;

  always_comb rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_q = rst_pipe_q[1];

  logic [ROW_AW-1:0] a_row, b_row;
  logic [WIDE_W-1:0] a_mask, b_mask, a_word, b_word, a_rword, b_rword;

  mwdp_port_map #(.WIDE_W(WIDE_W), .PORT_W(A_W), .ROWS(ROWS)) u_map_a (
    .clk(clk), .rst_n(rst_q), .en(a_en), .we(a_we), .addr(a_addr),
    .wdata(a_wdata), .rword(a_rword), .row(a_row), .wmask(a_mask),
    .wword(a_word), .rdata(a_rdata)
  );

  mwdp_port_map #(.WIDE_W(WIDE_W), .PORT_W(B_W), .ROWS(ROWS)) u_map_b (
    .clk(clk), .rst_n(rst_q), .en(b_en), .we(b_we), .addr(b_addr),
    .wdata(b_wdata), .rword(b_rword), .row(b_row), .wmask(b_mask),
    .wword(b_word), .rdata(b_rdata)
  );

  mwdp_store #(.WIDE_W(WIDE_W), .ROWS(ROWS)) u_store (
    .clk(clk), .rst_n(rst_q),
    .a_en(a_en), .a_row(a_row), .a_mask(a_mask), .a_word(a_word), .a_rword(a_rword),
    .b_en(b_en), .b_row(b_row), .b_mask(b_mask), .b_word(b_word), .b_rword(b_rword)
  );

  // R7: an idle port keeps its read data
  assert_rdata_hold_a_R7: assert property (@(posedge clk) disable iff (!rst_q)
    !a_en |=> $stable(a_rdata));

  assert_rdata_hold_b_R7: assert property (@(posedge clk) disable iff (!rst_q)
    !b_en |=> $stable(b_rdata));

endmodule

// File: tb/mwdp_ram_tb_top.sv
`timescale 1ns/1ps
module mwdp_ram_tb_top;

  localparam int RR = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_en, a_we, b_en, b_we;
  logic [5:0]  a_addr;
  logic [7:0]  b_addr;
  logic [31:0] a_wdata, a_rdata;
  logic [7:0]  b_wdata, b_rdata;

  logic        h_a_en, h_a_we, h_b_en, h_b_we;
  logic [4:0]  h_a_addr;
  logic [3:0]  h_b_addr;
  logic [15:0] h_a_wdata, h_a_rdata;
  logic [31:0] h_b_wdata, h_b_rdata;

  always #2.5 clk = ~clk;

  mwdp_ram #(.WIDE_W(32), .ROWS(RR), .A_W(32), .B_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  // half-width port A over 32-bit rows (ratio 2)
  mwdp_ram #(.WIDE_W(32), .ROWS(16), .A_W(16), .B_W(32)) dut_h_i (
    .clk(clk), .rst_n(rst_n),
    .a_en(h_a_en), .a_we(h_a_we), .a_addr(h_a_addr), .a_wdata(h_a_wdata), .a_rdata(h_a_rdata),
    .b_en(h_b_en), .b_we(h_b_we), .b_addr(h_b_addr), .b_wdata(h_b_wdata), .b_rdata(h_b_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int          due;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       qa[$];
  item_t       qb[$];
  logic [31:0] shadow [RR];
  logic [31:0] last_a = '0;
  logic [31:0] last_b = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: pop expected items as their result cycle comes up
  always @(negedge clk) begin
    item_t it;
    while (qa.size() > 0 && qa[0].due <= cyc) begin
      it = qa.pop_front();
      if (it.due == cyc && ^it.exp !== 1'bx) check(it.tag, "port A", a_rdata, it.exp);
    end
    while (qb.size() > 0 && qb[0].due <= cyc) begin
      it = qb.pop_front();
      if (it.due == cyc && ^it.exp !== 1'bx) check(it.tag, "port B", {24'b0, b_rdata}, it.exp);
    end
  end

  // driver: one cycle on both ports, expectations from the shadow rows
  task automatic step(bit ae, bit awe, logic [5:0] aad, logic [31:0] awd, string at,
                      bit be, bit bwe, logic [7:0] bad, logic [7:0] bwd, string bt);
    item_t       it;
    logic [31:0] ea, eb, tmp;
    @(negedge clk);
    a_en = ae; a_we = awe; a_addr = aad; a_wdata = awd;
    b_en = be; b_we = bwe; b_addr = bad; b_wdata = bwd;
    tmp = shadow[bad[7:2]];
    ea = ae ? shadow[aad] : last_a;
    eb = be ? {24'b0, tmp[int'(bad[1:0])*8 +: 8]} : last_b;
    last_a = ea;
    last_b = eb;
    it.due = cyc + 1; it.exp = ea; it.tag = at; qa.push_back(it);
    it.due = cyc + 1; it.exp = eb; it.tag = bt; qb.push_back(it);
    if (ae && awe) shadow[aad] = awd;
    if (be && bwe) begin
      tmp = shadow[bad[7:2]];
      tmp[int'(bad[1:0])*8 +: 8] = bwd;
      shadow[bad[7:2]] = tmp;
    end
  endtask

  function automatic logic [31:0] pat(int r);
    return {8'(r), 8'(r ^ 8'h5A), 8'(~r), 8'(r + 8'h33)};
  endfunction

  initial begin
    rst_n = 1'b0;
    a_en = 0; a_we = 0; a_addr = '0; a_wdata = '0;
    b_en = 0; b_we = 0; b_addr = '0; b_wdata = '0;
    h_a_en = 0; h_a_we = 0; h_a_addr = '0; h_a_wdata = '0;
    h_b_en = 0; h_b_we = 0; h_b_addr = '0; h_b_wdata = '0;
    repeat (3) @(negedge clk);
    check("R9", "A in reset", a_rdata, 32'h0);
    check("R9", "B in reset", {24'b0, b_rdata}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9", "A after release", a_rdata, 32'h0);
    check("R9", "B after release", {24'b0, b_rdata}, 32'h0);

    // fill every row from the wide port; idle B must stay at zero
    for (int i = 0; i < RR; i++) step(1, 1, 6'(i), pat(i), "R4", 0, 0, 8'h0, 8'h0, "R9");
    // narrow reads over the whole range, top address included
    for (int i = 0; i < 256; i++) step(0, 0, 6'h0, 32'h0, "R7", 1, 0, 8'(i), 8'h0, "R2");
    // read-first on the wide port, then the new value
    step(1, 1, 6'd7, 32'hDEAD_BEEF, "R4", 0, 0, 8'h0, 8'h0, "R7");
    step(1, 0, 6'd7, 32'h0, "R3", 0, 0, 8'h0, 8'h0, "R7");
    // narrow write to row 9 slice 2: other slices untouched
    step(0, 0, 6'h0, 32'h0, "R7", 1, 1, 8'd38, 8'hE7, "R4");
    step(1, 0, 6'd9, 32'h0, "R6", 1, 0, 8'd38, 8'h0, "R3");
    // cross-port: B reads while A writes the same row
    step(1, 1, 6'd12, 32'h0BAD_F00D, "R5", 1, 0, 8'd49, 8'h0, "R5");
    step(0, 0, 6'h0, 32'h0, "R7", 1, 0, 8'd49, 8'h0, "R5");
    // cross-port: A reads while B writes the same row
    step(1, 0, 6'd20, 32'h0, "R5", 1, 1, 8'd80, 8'h3C, "R5");
    step(1, 0, 6'd20, 32'h0, "R5", 0, 0, 8'h0, 8'h0, "R7");
    // write enables with port enables low: nothing changes
    step(0, 1, 6'd3, 32'hFFFF_FFFF, "R8", 0, 1, 8'd13, 8'h00, "R8");
    step(0, 1, 6'd3, 32'h1111_2222, "R7", 0, 1, 8'd14, 8'hAA, "R7");
    step(1, 0, 6'd3, 32'h0, "R8", 1, 0, 8'd13, 8'h0, "R8");
    step(0, 0, 6'h0, 32'h0, "R8", 1, 0, 8'd14, 8'h0, "R8");
    // two private regions written in the same cycles
    for (int i = 0; i < 16; i++)
      step(1, 1, 6'(i), 32'h5000_0000 + i, "R11", 1, 1, 8'(128 + i), 8'(8'hC0 + i), "R11");
    for (int i = 0; i < 16; i++)
      step(1, 0, 6'(i), 32'h0, "R11", 1, 0, 8'(128 + i), 8'h0, "R11");
    // top narrow address lands in the last row's most-significant slice
    step(0, 0, 6'h0, 32'h0, "R7", 1, 1, 8'd255, 8'h99, "R1");
    step(1, 0, 6'd63, 32'h0, "R1", 1, 0, 8'd255, 8'h0, "R1");
    step(0, 0, 6'h0, 32'h0, "R7", 0, 0, 8'h0, 8'h0, "R7");
    step(0, 0, 6'h0, 32'h0, "R7", 0, 0, 8'h0, 8'h0, "R7");
    a_en = 0; b_en = 0;
    repeat (2) @(negedge clk);

    // half-width configuration
    h_b_en = 1; h_b_we = 1; h_b_addr = 4'd3; h_b_wdata = 32'h1234_5678;
    @(negedge clk);
    h_b_en = 0; h_b_we = 0; h_a_en = 1; h_a_addr = 5'd6;
    @(negedge clk);
    check("R10", "half slice 0", {16'b0, h_a_rdata}, 32'h5678);
    h_a_addr = 5'd7;
    @(negedge clk);
    check("R2", "half slice 1", {16'b0, h_a_rdata}, 32'h1234);
    h_a_we = 1; h_a_wdata = 16'hBEEF;
    @(negedge clk);
    check("R4", "half read-first", {16'b0, h_a_rdata}, 32'h1234);
    h_a_en = 0; h_a_we = 0; h_b_en = 1;
    @(negedge clk);
    h_b_en = 0;
    check("R10", "wide view after half write", h_b_rdata, 32'hBEEF_5678);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule